// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer set up through a single byte-wide configuration register. The stored byte packs three fields: a resolution code, a multiplier and a steering bit. The timeout is the multiplier times four raised to the resolution code, counted in periods of an external 16 Hz time-base tick. Software keeps the watchdog from firing by touching the register. A write loads a new setting. A read restarts the countdown with the setting already held.

When the countdown runs out, a sticky flag is set. The steering bit then picks the action. With the bit set, the block issues a one-clock system reset request, pulses a strobe that clears the century bit held in a neighbouring calendar register, and clears its own setting so that it stays disarmed. With the bit clear, the block issues a single one-clock interrupt pulse, keeps its setting, and stays stopped until the next write or read.

The register strobes are plain single-cycle commands. They are accepted on every clock with no back-pressure, so no valid/ready handshake is used. The tick input must be a one-clock pulse at 16 Hz.

Top module: `wdog_steer`

## Requirements
- R1: Configuration byte layout: bits [1:0] hold the resolution code R, bits [6:2] hold the multiplier M, and bit 7 is the steering bit. The timeout fires on exactly the (M × 4^R)-th tick after the countdown was last loaded. A tick on the same clock as the load is not counted.
- R2: A write stores the byte, which then reads back on `cfg_rdata`. It clears the sticky flag and restarts the countdown from the new value.
- R3: A setting whose timeout is zero disables the watchdog. This covers M = 0 with any R, including the all-zero byte. No pulse and no flag results, however many ticks arrive.
- R4: A read restarts the countdown from the stored value. It leaves the flag and the stored value unchanged.
- R5: On expiry, `wd_flag` goes high. It stays high until the next write, whatever ticks or reads follow.
- R6: On expiry with bit 7 set, `rst_req` and `cent_clr` are high for exactly one clock, and the stored byte becomes 0x00.
- R7: On expiry with bit 7 clear, `irq` is high for exactly one clock and `rst_req` stays low. The stored byte is kept, and no further expiry occurs until a write or read.
- R8: A write or read on the same clock as the final tick reloads the countdown, and no expiry occurs. When a write and a read arrive together, the write takes effect.
- R9: After reset, `cfg_rdata` is 0x00, all outputs are low, and the watchdog is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_rd | input | 1 | Read strobe; restarts the countdown |
| cfg_wdata | input | MULT_W+RES_W+1 | Byte to write |
| cfg_rdata | output | MULT_W+RES_W+1 | Stored configuration byte |
| tick_16hz | input | 1 | One-clock pulse at 16 Hz |
| wd_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | One-clock system reset request |
| irq | output | 1 | One-clock interrupt pulse |
| cent_clr | output | 1 | One-clock strobe that clears the neighbour's century bit |

## Verification
The bench builds the block with its default widths: a 5-bit multiplier and a 2-bit resolution code. This gives an 11-bit countdown of up to 1984 ticks. Because the tick is an input, the bench pulses it every second clock. Even the longest setting, M = 31 with R = 3, then expires within a few thousand cycles and is checked tick-exact. Settings with R = 0, 1, 2 and 3 separate the 4^R scaling from a plain shift. Kicks placed on the final tick exercise the reload priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Action taken when the countdown runs out, selected by the steering bit.
  typedef enum logic {
    ACT_IRQ = 1'b0,
    ACT_RST = 1'b1
  } wd_act_e;
endpackage

// File: rtl/wd_cfg_reg.sv
module wd_cfg_reg #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W  = MULT_W + RES_W + 1,
  localparam int LOAD_W = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              clr,
  output logic [REG_W-1:0]  q,
  output logic [LOAD_W-1:0] load_val,
  output wdog_pkg::wd_act_e act
);
  logic [REG_W-1:0]  src;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (wr)  q <= wdata;
    else if (clr) q <= '0;
  end

  // Reload source: the incoming byte on a write, the held byte on a read.
  assign src  = wr ? wdata : q;
  assign res  = src[RES_W-1:0];
  assign mult = src[RES_W +: MULT_W];
  assign load_val = LOAD_W'(mult) << {res, 1'b0};
  assign act  = wdog_pkg::wd_act_e'(q[REG_W-1]);
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int LOAD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              tick,
  output logic              expire
);
  logic [LOAD_W-1:0] cnt;
  logic              active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (kick) begin
      cnt    <= load_val;
      active <= (load_val != '0);
    end else if (active && tick) begin
      cnt <= cnt - LOAD_W'(1);
      if (cnt == LOAD_W'(1)) active <= 1'b0;
    end
  end

  assign expire = active & tick & (cnt == LOAD_W'(1)) & ~kick;
endmodule

// File: rtl/wd_expiry.sv
module wd_expiry (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  wdog_pkg::wd_act_e act,
  input  logic              wr,
  output logic              flag,
  output logic              rst_req,
  output logic              irq,
  output logic              cent_clr,
  output logic              cfg_clr
);
  logic to_rst;

  assign to_rst  = expire & (act == wdog_pkg::ACT_RST);
  assign cfg_clr = to_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      rst_req  <= 1'b0;
      irq      <= 1'b0;
      cent_clr <= 1'b0;
    end else begin
      if (wr)          flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      rst_req  <= to_rst;
      cent_clr <= to_rst;
      irq      <= expire & (act == wdog_pkg::ACT_IRQ);
    end
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic                    cfg_rd,
  input  logic [MULT_W+RES_W:0]   cfg_wdata,
  output logic [MULT_W+RES_W:0]   cfg_rdata,
  input  logic                    tick_16hz,
  output logic                    wd_flag,
  output logic                    rst_req,
  output logic                    irq,
  output logic                    cent_clr
);
  localparam int LOAD_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [LOAD_W-1:0] load_val;
  logic              expire;
  logic              cfg_clr;
  wdog_pkg::wd_act_e act;

  wd_cfg_reg #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .clr(cfg_clr),
    .q(cfg_rdata), .load_val(load_val), .act(act)
  );

  wd_counter #(.LOAD_W(LOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .kick(cfg_wr | cfg_rd), .load_val(load_val),
    .tick(tick_16hz), .expire(expire)
  );

  wd_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .act(act), .wr(cfg_wr),
    .flag(wd_flag), .rst_req(rst_req), .irq(irq), .cent_clr(cent_clr),
    .cfg_clr(cfg_clr)
  );
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             wd_flag,
  input logic             rst_req,
  input logic             irq,
  input logic             cent_clr
);
  p_wr_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)) && !wd_flag);
  p_rd_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !cfg_wr) |=> $stable(cfg_rdata) && (wd_flag == $past(wd_flag)));
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !cfg_wr) |=> wd_flag);
  p_flag_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> wd_flag);
  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_rst_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cent_clr && (cfg_rdata == '0));
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
endmodule

bind wdog_steer wdog_steer_chk #(.REG_W(MULT_W + RES_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wd_flag(wd_flag),
  .rst_req(rst_req), .irq(irq), .cent_clr(cent_clr)
);

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_rd = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tick_16hz = 1'b0;
  logic       wd_flag, rst_req, irq, cent_clr;

  int n_chk = 0;
  int n_fail = 0;
  int rst_cnt = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_steer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_16hz(tick_16hz),
    .wd_flag(wd_flag), .rst_req(rst_req), .irq(irq), .cent_clr(cent_clr)
  );

  always @(posedge clk) begin
    if (rst_req) rst_cnt <= rst_cnt + 1;
    if (irq)     irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_16hz = 1'b1;
      @(negedge clk) tick_16hz = 1'b0;
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = v; end
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic rd_cfg();
    @(negedge clk) cfg_rd = 1'b1;
    @(negedge clk) cfg_rd = 1'b0;
  endtask

  task automatic t_reset();
    check(cfg_rdata == 8'h00, "R9 rdata", cfg_rdata, 0);
    check({wd_flag, rst_req, irq, cent_clr} == 4'b0, "R9 outputs",
          {wd_flag, rst_req, irq, cent_clr}, 0);
    run_ticks(10);
    check(rst_cnt == 0 && irq_cnt == 0 && !irq && !rst_req, "R9 disabled", irq_cnt, 0);
  endtask

  // M=3 R=1 -> 12 ticks, interrupt steering
  task automatic t_irq_exact();
    int i0;
    wr_cfg(8'h0D);
    check(cfg_rdata == 8'h0D, "R2 readback", cfg_rdata, 8'h0D);
    i0 = irq_cnt;
    run_ticks(11);
    check(irq_cnt == i0 && !irq, "R1 early at 11 of 12", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R1 fire at 12", irq, 1);
    check(wd_flag == 1'b1 && rst_req == 1'b0, "R5 flag/R7 no reset", {wd_flag, rst_req}, 2);
    idle(1);
    check(irq == 1'b0, "R7 single pulse", irq, 0);
    check(cfg_rdata == 8'h0D, "R7 value kept", cfg_rdata, 8'h0D);
    i0 = irq_cnt;
    run_ticks(30);
    check(irq_cnt == i0 && !irq, "R7 stays stopped", irq_cnt, i0);
    check(wd_flag == 1'b1, "R5 flag sticky over ticks", wd_flag, 1);
  endtask

  task automatic t_read_restart();
    int i0;
    rd_cfg();
    check(wd_flag == 1'b1 && cfg_rdata == 8'h0D, "R4 read keeps flag/value",
          {wd_flag, cfg_rdata}, 9'h10D);
    i0 = irq_cnt;
    run_ticks(11);
    check(irq_cnt == i0 && !irq, "R4 no early fire", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R4 fire after read reload", irq, 1);
    wr_cfg(8'h10);   // M=4 R=0 -> 4 ticks
    check(wd_flag == 1'b0, "R2 write clears flag", wd_flag, 0);
    run_ticks(3);
    rd_cfg();
    i0 = irq_cnt;
    run_ticks(3);
    check(irq_cnt == i0 && !irq, "R4 read mid-count restarts", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R4 fire 4 ticks after read", irq, 1);
  endtask

  // M=2 R=2 -> 32 ticks
  task automatic t_res2();
    int i0;
    wr_cfg(8'h0A);
    i0 = irq_cnt;
    run_ticks(31);
    check(irq_cnt == i0 && !irq, "R1 R=2 early", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R1 R=2 fire at 32", irq, 1);
  endtask

  // steering set, M=5 R=0 -> 5 ticks
  task automatic t_reset_steer();
    int i0;
    wr_cfg(8'h94);
    i0 = irq_cnt;
    run_ticks(4);
    check(rst_cnt == 0 && !rst_req, "R6 early", rst_cnt, 0);
    run_ticks(1);
    check(rst_req && cent_clr, "R6 reset and century strobe", {rst_req, cent_clr}, 3);
    check(cfg_rdata == 8'h00, "R6 value cleared", cfg_rdata, 0);
    check(wd_flag == 1'b1, "R5 flag on reset expiry", wd_flag, 1);
    idle(1);
    check(!rst_req && !cent_clr, "R6 single pulse", {rst_req, cent_clr}, 0);
    check(irq_cnt == i0, "R6 no interrupt", irq_cnt, i0);
    rd_cfg();
    run_ticks(10);
    check(rst_cnt == 1 && !rst_req, "R6 disarmed after reset", rst_cnt, 1);
  endtask

  task automatic t_disable();
    int i0, r0;
    wr_cfg(8'h00);
    i0 = irq_cnt; r0 = rst_cnt;
    run_ticks(70);
    check(irq_cnt == i0 && rst_cnt == r0 && !wd_flag, "R3 zero byte", irq_cnt, i0);
    wr_cfg(8'h83);   // M=0 R=3
    rd_cfg();
    run_ticks(70);
    check(rst_cnt == r0 && !rst_req && !wd_flag, "R3 M=0 R=3", rst_cnt, r0);
    check(cfg_rdata == 8'h83, "R3 value held", cfg_rdata, 8'h83);
  endtask

  task automatic t_kick_race();
    int i0;
    wr_cfg(8'h08);   // M=2 -> 2 ticks
    run_ticks(1);
    @(negedge clk) begin tick_16hz = 1'b1; cfg_rd = 1'b1; end
    @(negedge clk) begin tick_16hz = 1'b0; cfg_rd = 1'b0; end
    i0 = irq_cnt;
    check(!irq && !wd_flag, "R8 read beats final tick", irq, 0);
    run_ticks(1);
    check(irq_cnt == i0 && !irq, "R8 reload full", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R8 fire after reload", irq, 1);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_wdata = 8'h2C; end
    @(negedge clk) begin cfg_wr = 1'b0; cfg_rd = 1'b0; end
    check(cfg_rdata == 8'h2C && !wd_flag, "R8 write wins over read",
          cfg_rdata, 8'h2C);
  endtask

  // M=31 R=3 -> 1984 ticks
  task automatic t_max();
    int i0;
    wr_cfg(8'h7F);
    i0 = irq_cnt;
    run_ticks(1983);
    check(irq_cnt == i0 && !irq, "R1 max early", irq_cnt, i0);
    run_ticks(1);
    check(irq == 1'b1, "R1 max fire at 1984", irq, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_irq_exact();
    t_read_restart();
    t_res2();
    t_reset_steer();
    t_disable();
    t_kick_race();
    t_max();
    idle(2);
    finish_run();
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule